// File: doc/BRIEF.md
# Integer Multiply and Divide Unit

This unit carries out the eight 32-bit integer multiply and divide operations of a RISC-V style core. The caller presents two operands, the major opcode, the seven-bit function field, the three-bit operation selector and a one-cycle `start` strobe. It gets back a 32-bit `result` together with a one-cycle `done` strobe. The unit acts only when the opcode and the function field both identify the multiply-divide group. Otherwise `start` is dropped without a trace.

Multiplication is worked out in a single cycle. The result is registered, so `done` appears on the cycle after `start`. Division and remainder use a restoring shift-subtract divider on the operand magnitudes. It runs one quotient bit per cycle, and `busy` is high for the whole run. Signs and the two special cases are applied when the last bit is produced. Every division takes the same number of cycles, including division by zero and signed overflow. While the divider is busy, any new `start` is ignored.

Top module: `mdu_top`

## Requirements
- R1: A `start` is accepted only when `opcode` is 7'b0110011 and `funct7` is 7'b0000001. For any other value of either field, no `done` pulse follows, `busy` stays low and `result` keeps its previous value.
- R2: `funct3` selects the operation as follows: 000 low product, 001 signed×signed high, 010 signed×unsigned high, 011 unsigned×unsigned high, 100 signed quotient, 101 unsigned quotient, 110 signed remainder, 111 unsigned remainder.
- R3: The low-product operation returns bits 31:0 of the 64-bit product of `op_a` and `op_b`.
- R4: The three high-product operations return bits 63:32 of the 64-bit product. Both operands are signed for 001, both are unsigned for 011, and for 010 `op_a` is signed while `op_b` is unsigned.
- R5: Signed division rounds the quotient toward zero, and the signed remainder takes the sign of the dividend. The unsigned forms treat both operands as unsigned.
- R6: For a divisor of zero, the quotient is all ones and the remainder equals the dividend, in both signed and unsigned forms.
- R7: A signed division of 0x80000000 by 0xFFFFFFFF gives a quotient of 0x80000000 and a remainder of 0.
- R8: After an accepted multiply, `done` is high for exactly the one cycle after the `start` cycle, `result` is valid in that cycle, and `busy` stays low.
- R9: After an accepted divide or remainder, `busy` is high for exactly 32 cycles. `done` is then high for a single cycle, the one in which `busy` has just fallen, and `done` and `busy` are never high together.
- R10: A `start` that arrives while `busy` is high is ignored. The running operation completes with its own result, and no extra `done` follows.
- R11: During and directly after reset, `done` and `busy` are low and `result` is zero. `result` changes only in a cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request strobe |
| opcode | input | 7 | Major opcode of the instruction |
| funct7 | input | 7 | Function field that identifies the group |
| funct3 | input | 3 | Operation selector |
| op_a | input | 32 | First operand (multiplicand or dividend) |
| op_b | input | 32 | Second operand (multiplier or divisor) |
| busy | output | 1 | Divider is running |
| done | output | 1 | Result valid this cycle |
| result | output | 32 | Result of the last completed operation |

## Verification
The embedded assertions check the timing rules on every cycle. They cover the one-cycle multiply response, the start of a divide, the exact 32-cycle busy window measured by an independent counter, the mutual exclusion of `done` and `busy`, a silent response to a mismatched decode, and the rule that `result` changes only while `done` is high. The arithmetic values can only be shown by the bench's scenarios. These are the vector table across all eight selectors, the zero-divisor and overflow cases, the signed rounding cases, and the directed tests for a mismatched decode and a `start` issued while busy.

// File: rtl/mdu_pkg.sv
`timescale 1ns/1ps
package mdu_pkg;

  localparam int XLEN = 32;

  typedef enum logic [2:0] {
    OP_MUL    = 3'b000,
    OP_MULH   = 3'b001,
    OP_MULHSU = 3'b010,
    OP_MULHU  = 3'b011,
    OP_DIV    = 3'b100,
    OP_DIVU   = 3'b101,
    OP_REM    = 3'b110,
    OP_REMU   = 3'b111
  } md_op_e;

  // Product of two operands, each sign- or zero-extended by one bit.
  function automatic logic [XLEN-1:0] md_mul(input md_op_e op,
                                             input logic [XLEN-1:0] a,
                                             input logic [XLEN-1:0] b);
    logic               sa, sb;
    logic [XLEN:0]      ea, eb;
    logic signed [2*XLEN+1:0] prod;
    sa   = (op == OP_MULH) || (op == OP_MULHSU);
    sb   = (op == OP_MULH);
    ea   = {sa & a[XLEN-1], a};
    eb   = {sb & b[XLEN-1], b};
    prod = $signed(ea) * $signed(eb);
    if (op == OP_MUL) return prod[XLEN-1:0];
    return prod[2*XLEN-1:XLEN];
  endfunction

  // Magnitude of an operand (unchanged when treated as unsigned).
  function automatic logic [XLEN-1:0] md_mag(input logic [XLEN-1:0] x,
                                             input logic sgn);
    return (sgn && x[XLEN-1]) ? (~x + 1'b1) : x;
  endfunction

  // Final value once all quotient bits are known.
  function automatic logic [XLEN-1:0] md_fix(input logic [XLEN-1:0] quo,
                                             input logic [XLEN-1:0] rem,
                                             input logic want_rem,
                                             input logic neg_q,
                                             input logic neg_r,
                                             input logic by_zero,
                                             input logic [XLEN-1:0] dividend);
    if (by_zero) return want_rem ? dividend : '1;
    if (want_rem) return neg_r ? (~rem + 1'b1) : rem;
    return neg_q ? (~quo + 1'b1) : quo;
  endfunction

endpackage

// File: rtl/mdu_decode.sv
`timescale 1ns/1ps
module mdu_decode
  import mdu_pkg::*;
#(
  parameter logic [6:0] GROUP_OPCODE = 7'b0110011,
  parameter logic [6:0] GROUP_FUNCT7 = 7'b0000001
) (
  input  logic [6:0] opcode,
  input  logic [6:0] funct7,
  input  logic [2:0] funct3,
  output logic       hit,
  output logic       is_div,
  output md_op_e     op
);
  always_comb begin
    hit    = (opcode == GROUP_OPCODE) && (funct7 == GROUP_FUNCT7);
    op     = md_op_e'(funct3);
    is_div = funct3[2];
  end
endmodule

// File: rtl/mdu_mult.sv
`timescale 1ns/1ps
module mdu_mult
  import mdu_pkg::*;
(
  input  md_op_e          op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] value
);
  always_comb value = md_mul(op, a, b);
endmodule

// File: rtl/mdu_div.sv
`timescale 1ns/1ps
module mdu_div
  import mdu_pkg::*;
#(
  parameter int ITER = XLEN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  md_op_e          op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            busy,
  output logic            fin,
  output logic [XLEN-1:0] fin_value
);
  localparam int CW = $clog2(ITER) + 1;
  localparam logic [CW-1:0] LAST = CW'(ITER - 1);

  logic [XLEN-1:0] rem_q, quo_q, dvs_q, dvd_q;
  logic [CW-1:0]   cnt_q;
  logic            busy_q, neg_q, neg_r, want_rem_q, zero_q;

  logic            sgn;
  logic [XLEN:0]   shifted, diff;
  logic [XLEN-1:0] rem_nx, quo_nx;

  assign sgn = (op == OP_DIV) || (op == OP_REM);

  // One restoring step: shift in a dividend bit and try the subtraction.
  always_comb begin
    shifted = {rem_q, quo_q[XLEN-1]};
    diff    = shifted - {1'b0, dvs_q};
    if (!diff[XLEN]) begin
      rem_nx = diff[XLEN-1:0];
      quo_nx = {quo_q[XLEN-2:0], 1'b1};
    end else begin
      rem_nx = shifted[XLEN-1:0];
      quo_nx = {quo_q[XLEN-2:0], 1'b0};
    end
  end

  assign fin       = busy_q && (cnt_q == LAST);
  assign fin_value = md_fix(quo_nx, rem_nx, want_rem_q, neg_q, neg_r, zero_q, dvd_q);
  assign busy      = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      rem_q      <= '0;
      quo_q      <= '0;
      dvs_q      <= '0;
      dvd_q      <= '0;
      neg_q      <= 1'b0;
      neg_r      <= 1'b0;
      want_rem_q <= 1'b0;
      zero_q     <= 1'b0;
    end else if (load && !busy_q) begin
      busy_q     <= 1'b1;
      cnt_q      <= '0;
      rem_q      <= '0;
      quo_q      <= md_mag(a, sgn);
      dvs_q      <= md_mag(b, sgn);
      dvd_q      <= a;
      neg_q      <= sgn && (a[XLEN-1] ^ b[XLEN-1]);
      neg_r      <= sgn && a[XLEN-1];
      want_rem_q <= op[1];
      zero_q     <= (b == '0);
    end else if (busy_q) begin
      rem_q  <= rem_nx;
      quo_q  <= quo_nx;
      cnt_q  <= cnt_q + 1'b1;
      if (fin) busy_q <= 1'b0;
    end
  end

  // R9: a load always opens a fresh run from iteration zero
  p_load_starts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !busy_q) |=> (busy_q && cnt_q == '0));

endmodule

// File: rtl/mdu_top.sv
`timescale 1ns/1ps
module mdu_top
  import mdu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [6:0]  opcode,
  input  logic [6:0]  funct7,
  input  logic [2:0]  funct3,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  output logic        busy,
  output logic        done,
  output logic [31:0] result
);
  localparam int ITER = XLEN;
  localparam int RW   = $clog2(ITER) + 2;

  logic            dec_hit, dec_div;
  md_op_e          dec_op;
  logic [XLEN-1:0] mul_value, div_value;
  logic            div_busy, div_fin;
  logic            accept, mul_acc, div_load;
  logic            done_q;
  logic [XLEN-1:0] result_q;

  mdu_decode u_dec (
    .opcode (opcode),
    .funct7 (funct7),
    .funct3 (funct3),
    .hit    (dec_hit),
    .is_div (dec_div),
    .op     (dec_op)
  );

  mdu_mult u_mul (
    .op    (dec_op),
    .a     (op_a),
    .b     (op_b),
    .value (mul_value)
  );

  mdu_div #(.ITER(ITER)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (div_load),
    .op        (dec_op),
    .a         (op_a),
    .b         (op_b),
    .busy      (div_busy),
    .fin       (div_fin),
    .fin_value (div_value)
  );

  // Internal events brought out as named wires
  assign accept   = start && dec_hit && !div_busy;
  assign mul_acc  = accept && !dec_div;
  assign div_load = accept && dec_div;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      done_q <= mul_acc || div_fin;
      if (mul_acc)      result_q <= mul_value;
      else if (div_fin) result_q <= div_value;
    end
  end

  assign busy   = div_busy;
  assign done   = done_q;
  assign result = result_q;

  // Independent run-length counter of the busy window
  logic [RW-1:0] busy_run;
  always_ff @(posedge clk) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else           busy_run <= '0;
  end

  p_ignore_nonmatch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !dec_hit && !busy) |=> (!done && !busy));

  p_mul_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && dec_hit && !dec_div && !busy) |=> (done && !busy));

  p_div_enters_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && dec_hit && dec_div && !busy) |=> busy);

  p_busy_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && busy_run == RW'(ITER)));

  p_done_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  p_result_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

endmodule

// File: tb/mdu_top_tb_top.sv
`timescale 1ns/1ps
module mdu_top_tb_top;

  localparam logic [6:0] OPC = 7'b0110011;
  localparam logic [6:0] F7  = 7'b0000001;
  localparam int NV = 24;

  // {funct3, op_a, op_b, expected}
  localparam logic [98:0] VEC [NV] = '{
    {3'b000, 32'd7,         32'd6,         32'h0000002A},  // R3
    {3'b000, 32'hFFFFFFFF,  32'd3,         32'hFFFFFFFD},  // R3
    {3'b000, 32'h00010000,  32'h00010001,  32'h00010000},  // R3 wrap
    {3'b001, 32'hFFFFFFFF,  32'hFFFFFFFF,  32'h00000000},  // R4 MULH -1*-1
    {3'b001, 32'h80000000,  32'h80000000,  32'h40000000},  // R4 MULH
    {3'b001, 32'hFFFFFFFF,  32'd2,         32'hFFFFFFFF},  // R4 MULH -2
    {3'b011, 32'hFFFFFFFF,  32'hFFFFFFFF,  32'hFFFFFFFE},  // R4 MULHU
    {3'b011, 32'h80000000,  32'd2,         32'h00000001},  // R4 MULHU
    {3'b010, 32'hFFFFFFFF,  32'hFFFFFFFF,  32'hFFFFFFFF},  // R4 MULHSU
    {3'b010, 32'd2,         32'h80000000,  32'h00000001},  // R4 MULHSU
    {3'b100, 32'hFFFFFFF9,  32'd2,         32'hFFFFFFFD},  // R5 -7/2
    {3'b110, 32'hFFFFFFF9,  32'd2,         32'hFFFFFFFF},  // R5 -7%2
    {3'b100, 32'd7,         32'hFFFFFFFE,  32'hFFFFFFFD},  // R5 7/-2
    {3'b110, 32'd7,         32'hFFFFFFFE,  32'h00000001},  // R5 7%-2
    {3'b110, 32'hFFFFFFF8,  32'd3,         32'hFFFFFFFE},  // R5 -8%3
    {3'b101, 32'hFFFFFFFF,  32'd2,         32'h7FFFFFFF},  // R5 DIVU
    {3'b111, 32'hFFFFFFFF,  32'd2,         32'h00000001},  // R5 REMU
    {3'b101, 32'd100,       32'd10,        32'd10},        // R5 DIVU
    {3'b100, 32'd5,         32'd0,         32'hFFFFFFFF},  // R6
    {3'b110, 32'hFFFFFFFB,  32'd0,         32'hFFFFFFFB},  // R6
    {3'b101, 32'h80000000,  32'd0,         32'hFFFFFFFF},  // R6
    {3'b111, 32'h80000000,  32'd0,         32'h80000000},  // R6
    {3'b100, 32'h80000000,  32'hFFFFFFFF,  32'h80000000},  // R7
    {3'b110, 32'h80000000,  32'hFFFFFFFF,  32'h00000000}   // R7
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  opcode = '0;
  logic [6:0]  funct7 = '0;
  logic [2:0]  funct3 = '0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        busy, done;
  logic [31:0] result;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mdu_top dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .opcode(opcode), .funct7(funct7), .funct3(funct3),
    .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .result(result)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // Issue one request and wait for done; latency counted in cycles after start.
  task automatic run_op(input logic [6:0] opc, input logic [6:0] f7, input logic [2:0] f3,
                        input logic [31:0] a, input logic [31:0] b,
                        output logic [31:0] res, output int lat, output int bcyc,
                        output bit seen, output int after_done);
    @(negedge clk);
    opcode = opc; funct7 = f7; funct3 = f3; op_a = a; op_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1; bcyc = 0;
    while (!done && lat < 60) begin
      if (busy) bcyc++;
      @(negedge clk);
      lat++;
    end
    seen = done;
    res = result;
    @(negedge clk);
    after_done = int'(done);
  endtask

  initial begin
    logic [31:0] res;
    int lat, bcyc, after;
    bit seen;

    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 done in reset", {31'd0, done}, 32'd0);
    check("R11 busy in reset", {31'd0, busy}, 32'd0);
    check("R11 result in reset", result, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 result after reset", result, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] f3v;
      f3v = VEC[i][98:96];
      run_op(OPC, F7, f3v, VEC[i][95:64], VEC[i][63:32], res, lat, bcyc, seen, after);
      check($sformatf("R2 vector %0d done seen", i), {31'd0, seen}, 32'd1);
      check($sformatf("R2 vector %0d funct3 %0b value", i, f3v), res, VEC[i][31:0]);
      check($sformatf("R9 vector %0d single done pulse", i), after, 0);
      if (f3v[2]) begin
        check($sformatf("R9 vector %0d divide latency", i), lat, 33);
        check($sformatf("R9 vector %0d busy cycles", i), bcyc, 32);
      end else begin
        check($sformatf("R8 vector %0d multiply latency", i), lat, 1);
        check($sformatf("R8 vector %0d busy cycles", i), bcyc, 0);
      end
    end

    // R11: result holds between completions
    repeat (5) @(negedge clk);
    check("R11 result held", result, 32'h00000000);

    // R1: wrong opcode is ignored
    run_op(7'b0110111, F7, 3'b000, 32'd9, 32'd9, res, lat, bcyc, seen, after);
    check("R1 opcode mismatch no done", {31'd0, seen}, 32'd0);
    check("R1 opcode mismatch no busy", bcyc, 0);
    check("R1 opcode mismatch result kept", res, 32'h00000000);

    // R1: wrong funct7 on a divide is ignored
    run_op(OPC, 7'b0000000, 3'b101, 32'd50, 32'd5, res, lat, bcyc, seen, after);
    check("R1 funct7 mismatch no done", {31'd0, seen}, 32'd0);
    check("R1 funct7 mismatch no busy", bcyc, 0);
    check("R1 funct7 mismatch result kept", res, 32'h00000000);

    // R10: start while busy is ignored
    begin
      int dones;
      int first_at;
      dones = 0; first_at = 0;
      @(negedge clk);
      opcode = OPC; funct7 = F7; funct3 = 3'b101; op_a = 32'd100; op_b = 32'd7; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int c = 1; c <= 45; c++) begin
        if (c == 5) begin
          funct3 = 3'b000; op_a = 32'd3; op_b = 32'd3; start = 1'b1;
        end else begin
          start = 1'b0;
        end
        if (done) begin
          dones++;
          if (first_at == 0) begin
            first_at = c;
            check("R10 running divide result kept", result, 32'd14);
          end
        end
        @(negedge clk);
      end
      check("R10 exactly one done", dones, 1);
      check("R10 done at divide latency", first_at, 33);
      check("R10 result after ignored start", result, 32'd14);
    end

    // R6/R5: one more zero divisor and a normal signed case back to back
    run_op(OPC, F7, 3'b111, 32'd1234, 32'd0, res, lat, bcyc, seen, after);
    check("R6 REMU by zero", res, 32'd1234);
    run_op(OPC, F7, 3'b100, 32'hFFFFFF9C, 32'd7, res, lat, bcyc, seen, after);
    check("R5 -100/7 toward zero", res, 32'hFFFFFFF2);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800us;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule